// File: doc/BRIEF.md
# Power-Gating Interval Timer Controller

This controller drives an active-low enable for a load switch that powers a downstream circuit for part of each timing interval. Time is measured in ticks of a slow time base, supplied as a single-cycle tick-enable pulse. The interval length in ticks and the operating mode are presented on static configuration inputs and captured when a configuration strobe arrives. After capture the controller powers the load at once.

In periodic mode the load is powered at the start of every interval. In one-shot mode it is powered once after configuration and afterwards only by a manual trigger. Each on-pulse ends a fixed guard of `GUARD` ticks before the interval closes, so the load is always off at the boundary. A rising edge on the load's completion input ends the pulse early. Only the first such edge in an interval is acted on.

A separate debouncer supplies single-cycle "manual trigger valid" and "manual released" events. While the load is off, a trigger powers it, clears the interval count and holds it on until the release event. Completion edges are ignored during that time, and a fresh interval begins when the release arrives.

Top module: `pg_interval_timer`

## Requirements
- R1: After reset `gate_n` is 1 and stays 1, whatever ticks arrive, until `cfg_done` is seen. On the `cfg_done` cycle `cfg_interval` and `cfg_periodic` are captured, and `gate_n` is 0 from the next cycle.
- R2: In periodic mode (`cfg_periodic`=1 at capture) `gate_n` falls at every interval boundary. A boundary is the tick that brings the tick count since the last start up to the captured interval, so adjacent falling edges are exactly one interval apart.
- R3: With no completion edge, `gate_n` stays 0 for interval minus `GUARD` ticks after each start, then stays 1 for the last `GUARD` ticks. After tick number j since the last start, the load is on exactly when j < interval − `GUARD`.
- R4: A rising edge on `done_in` while the load is powered by the timer drives `gate_n` to 1 within 100 ns, that is, within 20 cycles at 200 MHz. A pulse 100 ns wide is enough. Once `gate_n` is 1 it stays 1 until the next interval start. An edge in a later interval is honoured again.
- R5: In one-shot mode (`cfg_periodic`=0 at capture) exactly one on-pulse of interval minus `GUARD` ticks follows configuration. After it `gate_n` stays 1 across later ticks.
- R6: A `man_trig` event while `gate_n` is 1 (after configuration) drives `gate_n` to 0 on the next cycle and clears the count. `gate_n` stays 0 across ticks and `done_in` edges until `man_rel`. After `man_rel` a new interval starts with the R3 timing.
- R7: A `man_trig` event while `gate_n` is 0 is ignored. The running interval keeps its R2/R3 timing.
- R8: Changes on `cfg_periodic` and `cfg_interval` after capture have no effect. `GUARD` ≥ 1 and captured intervals must exceed `GUARD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle time-base enable, one per tick |
| cfg_done | input | 1 | Configuration strobe; captures interval and mode |
| cfg_periodic | input | 1 | Mode: 1 periodic, 0 one-shot |
| cfg_interval | input | IW | Interval length in ticks |
| done_in | input | 1 | Asynchronous completion input from the load |
| man_trig | input | 1 | Validated manual-trigger event (one cycle) |
| man_rel | input | 1 | Manual-release event (one cycle) |
| gate_n | output | 1 | Active-low load-switch enable |

## Verification
The bench sweeps five interval lengths just above a 3-tick guard in both modes. After every tick it compares the gate with an arithmetic prediction from the tick index and interval, which separates errors in the guard length from errors in period length and one-shot termination. Completion pulses of exactly 100 ns are sent early in the first interval and again in the next one, which shows both the response window and the re-arming of the edge at each interval. Manual triggers are sent while the load is off in one-shot mode, with ticks and completion pulses applied during the hold, and while the load is on in periodic mode. Together these tell a correct hold-and-restart apart from a trigger that is wrongly honoured.

// File: rtl/pg_interval_timer.sv
module pg_interval_timer #(
  parameter int IW    = 16,
  parameter int GUARD = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_done,
  input  logic          cfg_periodic,
  input  logic [IW-1:0] cfg_interval,
  input  logic          done_in,
  input  logic          man_trig,
  input  logic          man_rel,
  output logic          gate_n
);

  localparam logic [IW-1:0] GD = IW'(GUARD);

  typedef enum logic [2:0] {S_CFG, S_ON, S_OFF, S_IDLE, S_HOLD} state_t;

  state_t        state;
  logic [IW-1:0] cnt, ival;
  logic          periodic, done_used;
  logic [2:0]    dsync;

  wire [IW-1:0] cnt_nx    = cnt + 1'b1;
  wire          done_rise = dsync[1] & ~dsync[2];
  wire          end_on    = tick && (cnt_nx == ival - GD);
  wire          end_iv    = tick && (cnt_nx == ival);

  assign gate_n = !(state == S_ON || state == S_HOLD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dsync <= '0;
    else        dsync <= {dsync[1:0], done_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_CFG;
      cnt       <= '0;
      ival      <= '0;
      periodic  <= 1'b0;
      done_used <= 1'b0;
    end else begin
      unique case (state)
        S_CFG: if (cfg_done) begin
          ival      <= cfg_interval;
          periodic  <= cfg_periodic;
          cnt       <= '0;
          done_used <= 1'b0;
          state     <= S_ON;
        end
        S_ON: begin
          if (tick) cnt <= cnt_nx;
          if (end_on) state <= S_OFF;
          else if (done_rise && !done_used) begin
            state     <= S_OFF;
            done_used <= 1'b1;
          end
        end
        S_OFF: begin
          if (man_trig) begin
            cnt   <= '0;
            state <= S_HOLD;
          end else if (end_iv) begin
            cnt       <= '0;
            done_used <= 1'b0;
            state     <= periodic ? S_ON : S_IDLE;
          end else if (tick) cnt <= cnt_nx;
        end
        S_IDLE: if (man_trig) begin
          cnt   <= '0;
          state <= S_HOLD;
        end
        S_HOLD: begin
          cnt <= '0;
          if (man_rel) begin
            done_used <= 1'b0;
            state     <= S_ON;
          end
        end
        default: state <= S_CFG;
      endcase
    end
  end

  a_r1_cfg_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CFG && cfg_done) |=> !gate_n);

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ON || state == S_OFF) |-> cnt < ival);

  a_r4_done_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ON && done_rise && !done_used) |=> gate_n);

  a_r5_idle_only_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !periodic);

  a_r6_trig_powers_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE || state == S_OFF) && man_trig) |=> !gate_n);

  a_r6_hold_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !man_rel) |=> (state == S_HOLD && !gate_n));

  a_r7_trig_ignored_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ON && man_trig) |=> state != S_HOLD);

endmodule

// File: tb/test_pg_interval_timer.sv
`timescale 1ns/1ps
module test_pg_interval_timer;

  localparam int IW = 8;
  localparam int G  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cfg_done = 0, cfg_periodic = 0, done_in = 0, man_trig = 0, man_rel = 0;
  logic [IW-1:0] cfg_interval = '0;
  logic gate_n;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  pg_interval_timer #(.IW(IW), .GUARD(G)) i_pg_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_done(cfg_done),
    .cfg_periodic(cfg_periodic), .cfg_interval(cfg_interval), .done_in(done_in),
    .man_trig(man_trig), .man_rel(man_rel), .gate_n(gate_n));

  task automatic check(input logic exp, input string req);
    nchk++;
    if (gate_n !== exp) begin
      nerr++;
      $display("FAIL %s: gate_n=%b expected %b at %0t", req, gate_n, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic configure(input int iv, input logic per);
    @(negedge clk);
    cfg_interval = IW'(iv);
    cfg_periodic = per;
    cfg_done = 1'b1;
    @(negedge clk) cfg_done = 1'b0;
    check(1'b0, "R1");
    cfg_periodic = ~per;
    cfg_interval = IW'(iv + 7);
  endtask

  task automatic pulse_done();
    @(negedge clk) done_in = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    // R1: idle until configured
    do_reset();
    check(1'b1, "R1");
    for (int k = 0; k < 3; k++) begin
      do_tick();
      check(1'b1, "R1");
    end

    // R2, R3, R8: periodic sweep
    for (int iv = G + 1; iv <= G + 5; iv++) begin
      do_reset();
      configure(iv, 1'b1);
      for (int j = 1; j <= 3 * iv; j++) begin
        do_tick();
        check(((j % iv) < (iv - G)) ? 1'b0 : 1'b1, (j % iv == 0) ? "R2" : "R3");
      end
    end

    // R5, R6, R8: one-shot sweep with manual retrigger
    for (int iv = G + 1; iv <= G + 5; iv++) begin
      do_reset();
      configure(iv, 1'b0);
      for (int j = 1; j <= 2 * iv; j++) begin
        do_tick();
        check((j < iv - G) ? 1'b0 : 1'b1, "R5");
      end
      pulse(man_trig);
      check(1'b0, "R6");
      for (int k = 0; k < 3; k++) begin
        do_tick();
        check(1'b0, "R6");
      end
      pulse_done();
      check(1'b0, "R6");
      done_in = 1'b0;
      repeat (4) @(negedge clk);
      pulse(man_rel);
      check(1'b0, "R6");
      for (int j = 1; j <= 2 * iv; j++) begin
        do_tick();
        check((j < iv - G) ? 1'b0 : 1'b1, "R6");
      end
    end

    // R4: completion edge ends pulse early, re-armed next interval
    do_reset();
    configure(G + 5, 1'b1);
    do_tick();
    check(1'b0, "R4");
    pulse_done();
    check(1'b1, "R4");
    done_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int j = 2; j <= G + 6; j++) begin
      do_tick();
      check((j == G + 5 || j == G + 6) ? 1'b0 : 1'b1, "R4");
    end
    pulse_done();
    check(1'b1, "R4");
    done_in = 1'b0;
    repeat (4) @(negedge clk);

    // R7: trigger while on is ignored
    do_reset();
    configure(G + 4, 1'b1);
    pulse(man_trig);
    check(1'b0, "R7");
    for (int j = 1; j <= 2 * (G + 4); j++) begin
      do_tick();
      check(((j % (G + 4)) < 4) ? 1'b0 : 1'b1, "R7");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule